// File: doc/BRIEF.md
# Dual-Channel PCM Time-Slot Port

This block joins two voice channels to one serial line pair: a shared transmit data output and a shared receive data input, both timed by one bit clock. Each channel has its own transmit slot marker and its own receive slot marker. A marker is a free-running pulse, one per frame. The clock edge at which a marker is first seen high starts that channel's 8-bit slot. Markers may fall at any bit offset in the frame, so slots do not need byte alignment. A channel can use one signal for both markers, which gives simultaneous transmit and receive.

On the parallel side, each channel has a transmit sample input with valid and ready strobes, and a receive sample output with a one-cycle valid strobe. The transmit line comes with an output enable that an outside pad uses as its tri-state control. The enable is high only during an active transmit slot.

Each channel and direction is handled by a lane with two states. `LANE_IDLE` waits for an accepted slot start. `LANE_SHIFT` moves one bit per clock. The lane has three transitions:
- IDLE to SHIFT on a marker rising edge.
- SHIFT to IDLE after the eighth bit when no new edge arrives.
- SHIFT to SHIFT when a marker edge coincides with the eighth bit, giving back-to-back slots.

Top module: `pcm_dual_port`

## Requirements
- R1: After reset, `tx_oe`, `tx_line`, `tx_underrun`, `rx_valid`, `tx_clash` and `rx_clash` are all 0, and every `tx_ready` bit is 1.
- R2: A slot starts only at a clock edge where the channel's marker is sampled high after being sampled low. A marker held high for many cycles starts one slot. An edge on a channel whose own slot is still before its eighth bit is ignored.
- R3: When a transmit slot starts at edge k, `tx_line` carries the 8-bit byte MSB first. The bits appear in the periods after edges k to k+7, and `tx_oe` is high for exactly those 8 periods.
- R4: Whenever `tx_oe` is low, `tx_line` is 0.
- R5: `tx_ready[c]` is high while channel c holds no pending sample. A valid with ready high stores the sample and drops ready. The stored sample is sent at the next slot start, and ready returns after that edge. A valid at the slot-start edge itself, with ready high, is sent in that slot directly.
- R6: If a slot starts with no pending or same-edge sample, the last byte sent is repeated and `tx_underrun[c]` goes high. The flag drops at the next slot start that has a new sample. Before any sample the byte is 0x00.
- R7: A receive slot starting at edge k samples `rx_line` on the falling edges after edges k to k+7, MSB first. The byte appears on `rx_sample[c*8 +: 8]` after edge k+8, with `rx_valid[c]` high for that one cycle.
- R8: The two channels work independently on the shared lines. Tying a channel's transmit and receive markers together moves its transmit and receive bytes in the same slot.
- R9: `tx_clash` (or `rx_clash`) pulses for one cycle, after the edge at which a slot of that direction starts while another channel's slot of the same direction is before its eighth bit. A separation of exactly 8 bits is not a clash.
- R10: While transmit slots overlap, the lowest-numbered active channel drives `tx_line`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset |
| tx_sync | input | NCH | Transmit slot marker per channel |
| rx_sync | input | NCH | Receive slot marker per channel |
| tx_sample | input | NCH*W | Transmit samples, channel c in bits c*W +: W |
| tx_valid | input | NCH | Transmit sample valid per channel |
| tx_ready | output | NCH | Channel can accept a transmit sample |
| tx_underrun | output | NCH | Last slot start had no new sample |
| tx_line | output | 1 | Shared serial transmit data |
| tx_oe | output | 1 | Output enable for the transmit line |
| rx_line | input | 1 | Shared serial receive data |
| rx_sample | output | NCH*W | Received samples, channel c in bits c*W +: W |
| rx_valid | output | NCH | One-cycle strobe for a new received sample |
| tx_clash | output | 1 | Overlapping transmit slots detected |
| rx_clash | output | 1 | Overlapping receive slots detected |

## Verification
The assertions check these rules on every cycle:
- the transmit line is quiet whenever the enable is low;
- a pending sample stays pending until a slot consumes it;
- a slot start with no sample raises the underrun flag;
- every slot start leaves the lane shifting;
- each receive strobe lasts one cycle and follows a shifting period.

Only the bench's scenarios can show that whole bytes come out MSB first at arbitrary offsets. The same holds for:
- received bytes matching the line;
- a long marker giving a single slot;
- the same-edge bypass and the repeated byte on underrun;
- clash flagging at 4-bit versus exactly 8-bit spacing.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    localparam int DEF_SLOT_BITS = 8;
    localparam int DEF_CHANNELS  = 2;

    typedef enum logic {
        LANE_IDLE  = 1'b0,
        LANE_SHIFT = 1'b1
    } lane_state_e;

endpackage

// File: rtl/pcm_sync_edge.sv
module pcm_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync;
    end

    assign rise = sync & ~prev_q;
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
    import pcm_port_pkg::*;
#(
    parameter int W = DEF_SLOT_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sync,
    input  logic [W-1:0] smp_data,
    input  logic         smp_valid,
    output logic         smp_ready,
    output logic         underrun,
    output logic         ser_bit,
    output logic         busy,
    output logic         cont,
    output logic         start
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    lane_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     sr_q, hold_q, byte_sel;
    logic             fresh_q, under_q, rise, last_bit;

    pcm_sync_edge i_edge (.clk(clk), .rst_n(rst_n), .sync(sync), .rise(rise));

    assign last_bit = (state_q == LANE_SHIFT) && (cnt_q == LAST);
    assign start    = rise && ((state_q == LANE_IDLE) || last_bit);
    assign byte_sel = (!fresh_q && smp_valid) ? smp_data : hold_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LANE_IDLE:  if (start) state_d = LANE_SHIFT;
            LANE_SHIFT: if (last_bit && !start) state_d = LANE_IDLE;
            default:    state_d = LANE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LANE_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            sr_q    <= '0;
            hold_q  <= '0;
            fresh_q <= 1'b0;
            under_q <= 1'b0;
        end else if (start) begin
            cnt_q   <= '0;
            sr_q    <= byte_sel;
            hold_q  <= byte_sel;
            fresh_q <= 1'b0;
            under_q <= !(fresh_q || smp_valid);
        end else begin
            if (state_q == LANE_SHIFT) begin
                cnt_q <= cnt_q + 1'b1;
                sr_q  <= {sr_q[W-2:0], 1'b0};
            end
            if (smp_valid && !fresh_q) begin
                hold_q  <= smp_data;
                fresh_q <= 1'b1;
            end
        end
    end

    always_comb begin
        busy      = (state_q == LANE_SHIFT);
        cont      = busy && (cnt_q != LAST);
        ser_bit   = busy ? sr_q[W-1] : 1'b0;
        smp_ready = !fresh_q;
        underrun  = under_q;
    end

    a_r5_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_ready && !start) |=> !smp_ready);
    a_r6_empty_start_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (start && smp_ready && !smp_valid) |=> underrun);
    a_r3_start_shifts: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
    import pcm_port_pkg::*;
#(
    parameter int W = DEF_SLOT_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sync,
    input  logic         rx_bit,
    output logic [W-1:0] smp_data,
    output logic         smp_valid,
    output logic         cont,
    output logic         start
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    lane_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     acc_q, out_q;
    logic             valid_q, rise, last_bit, busy;

    pcm_sync_edge i_edge (.clk(clk), .rst_n(rst_n), .sync(sync), .rise(rise));

    assign busy     = (state_q == LANE_SHIFT);
    assign last_bit = busy && (cnt_q == LAST);
    assign start    = rise && (!busy || last_bit);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LANE_IDLE:  if (start) state_d = LANE_SHIFT;
            LANE_SHIFT: if (last_bit && !start) state_d = LANE_IDLE;
            default:    state_d = LANE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LANE_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            acc_q   <= '0;
            out_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (busy) begin
                acc_q <= {acc_q[W-2:0], rx_bit};
                cnt_q <= cnt_q + 1'b1;
            end
            if (last_bit) begin
                out_q   <= {acc_q[W-2:0], rx_bit};
                valid_q <= 1'b1;
            end
            if (start) cnt_q <= '0;
        end
    end

    always_comb begin
        cont      = busy && (cnt_q != LAST);
        smp_data  = out_q;
        smp_valid = valid_q;
    end

    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);
    a_r7_strobe_after_slot: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> $past(busy));
endmodule

// File: rtl/pcm_dual_port.sv
module pcm_dual_port
    import pcm_port_pkg::*;
#(
    parameter int NCH = DEF_CHANNELS,
    parameter int W   = DEF_SLOT_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   tx_sync,
    input  logic [NCH-1:0]   rx_sync,
    input  logic [NCH*W-1:0] tx_sample,
    input  logic [NCH-1:0]   tx_valid,
    output logic [NCH-1:0]   tx_ready,
    output logic [NCH-1:0]   tx_underrun,
    output logic             tx_line,
    output logic             tx_oe,
    input  logic             rx_line,
    output logic [NCH*W-1:0] rx_sample,
    output logic [NCH-1:0]   rx_valid,
    output logic             tx_clash,
    output logic             rx_clash
);
    logic [NCH-1:0] tx_busy, tx_cont, tx_start, tx_bits;
    logic [NCH-1:0] rx_cont, rx_start;
    logic           rx_q, tx_conflict, rx_conflict, tx_clash_q, rx_clash_q;

    // receive data is taken mid-bit, on the falling clock edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= 1'b0;
        else        rx_q <= rx_line;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pcm_tx_lane #(.W(W)) i_tx (
            .clk(clk), .rst_n(rst_n), .sync(tx_sync[c]),
            .smp_data(tx_sample[c*W +: W]), .smp_valid(tx_valid[c]),
            .smp_ready(tx_ready[c]), .underrun(tx_underrun[c]),
            .ser_bit(tx_bits[c]), .busy(tx_busy[c]),
            .cont(tx_cont[c]), .start(tx_start[c])
        );
        pcm_rx_lane #(.W(W)) i_rx (
            .clk(clk), .rst_n(rst_n), .sync(rx_sync[c]), .rx_bit(rx_q),
            .smp_data(rx_sample[c*W +: W]), .smp_valid(rx_valid[c]),
            .cont(rx_cont[c]), .start(rx_start[c])
        );
    end

    always_comb begin
        tx_line = 1'b0;
        for (int i = NCH - 1; i >= 0; i--)
            if (tx_busy[i]) tx_line = tx_bits[i];
        tx_oe = |tx_busy;
    end

    always_comb begin
        tx_conflict = 1'b0;
        rx_conflict = 1'b0;
        for (int i = 0; i < NCH; i++)
            for (int j = 0; j < NCH; j++)
                if (i != j) begin
                    if (tx_start[i] && tx_cont[j]) tx_conflict = 1'b1;
                    if (rx_start[i] && rx_cont[j]) rx_conflict = 1'b1;
                end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_clash_q <= 1'b0;
            rx_clash_q <= 1'b0;
        end else begin
            tx_clash_q <= tx_conflict;
            rx_clash_q <= rx_conflict;
        end
    end

    assign tx_clash = tx_clash_q;
    assign rx_clash = rx_clash_q;

    a_r4_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> !tx_line);
endmodule

// File: tb/test_pcm_dual_port.sv
module test_pcm_dual_port;
    localparam int PERIOD = 10;
    localparam int NCH = 2;
    localparam int W = 8;
    localparam int NCYC = 230;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] tx_sync = '0, rx_sync = '0, tx_valid = '0;
    logic [NCH*W-1:0] tx_sample = '0;
    logic rx_line = 1'b0;
    logic [NCH-1:0] tx_ready, tx_underrun, rx_valid;
    logic [NCH*W-1:0] rx_sample;
    logic tx_line, tx_oe, tx_clash, rx_clash;

    int checks = 0, failures = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    pcm_dual_port i_pcm_dual_port (
        .clk(clk), .rst_n(rst_n), .tx_sync(tx_sync), .rx_sync(rx_sync),
        .tx_sample(tx_sample), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_underrun(tx_underrun), .tx_line(tx_line), .tx_oe(tx_oe),
        .rx_line(rx_line), .rx_sample(rx_sample), .rx_valid(rx_valid),
        .tx_clash(tx_clash), .rx_clash(rx_clash)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // stimulus schedule
    function automatic bit in_pulse(input int n, input int s, input int len);
        return (n >= s) && (n < s + len);
    endfunction

    function automatic bit tsync_f(input int c, input int n);
        if (c == 0)
            return in_pulse(n,10,3) | in_pulse(n,50,1) | in_pulse(n,80,1) |
                   in_pulse(n,120,16) | in_pulse(n,160,2);
        return in_pulse(n,20,1) | in_pulse(n,58,1) | in_pulse(n,84,1) |
               in_pulse(n,110,1) | in_pulse(n,170,1);
    endfunction

    function automatic bit rsync_f(input int c, input int n);
        if (c == 0) return tsync_f(0, n);   // tied markers on channel 0 (R8)
        return in_pulse(n,35,1) | in_pulse(n,66,1) | in_pulse(n,85,1) |
               in_pulse(n,140,1) | in_pulse(n,185,1);
    endfunction

    function automatic bit tvalid_f(input int c, input int n);
        if (c == 0) return n == 5 || n == 40 || n == 100 || n == 115 || n == 150;
        return n == 6 || n == 20 || n == 45 || n == 110 || n == 165;
    endfunction

    // behavioural reference model
    int tpos[NCH], tbyte[NCH], thold[NCH], rpos[NCH], racc[NCH], rout[NCH];
    bit tfresh[NCH], tunder[NCH], tprev[NCH], rprev[NCH], rval[NCH];
    bit m_tclash, m_rclash;
    int m_rxs;

    task automatic model_step();
        bit tst[NCH], rst[NCH];
        int data;
        for (int c = 0; c < NCH; c++) begin
            tst[c] = tx_sync[c] && !tprev[c] && (tpos[c] < 0 || tpos[c] == 7);
            rst[c] = rx_sync[c] && !rprev[c] && (rpos[c] < 0 || rpos[c] == 7);
            tprev[c] = tx_sync[c];
            rprev[c] = rx_sync[c];
        end
        m_tclash = 0;
        m_rclash = 0;
        for (int c = 0; c < NCH; c++)
            for (int d = 0; d < NCH; d++)
                if (c != d) begin
                    if (tst[c] && tpos[d] >= 0 && tpos[d] != 7) m_tclash = 1;
                    if (rst[c] && rpos[d] >= 0 && rpos[d] != 7) m_rclash = 1;
                end
        for (int c = 0; c < NCH; c++) begin
            data = int'(tx_sample[c*W +: W]);
            if (tst[c]) begin
                if (tfresh[c]) begin
                    tbyte[c] = thold[c]; tfresh[c] = 0; tunder[c] = 0;
                end else if (tx_valid[c]) begin
                    tbyte[c] = data; thold[c] = data; tunder[c] = 0;
                end else begin
                    tbyte[c] = thold[c]; tunder[c] = 1;
                end
                tpos[c] = 0;
            end else begin
                if (tpos[c] >= 0) tpos[c] = (tpos[c] == 7) ? -1 : tpos[c] + 1;
                if (tx_valid[c] && !tfresh[c]) begin
                    thold[c] = data; tfresh[c] = 1;
                end
            end
            rval[c] = 0;
            if (rpos[c] >= 0) begin
                racc[c] = ((racc[c] << 1) | m_rxs) & 255;
                if (rpos[c] == 7) begin
                    rout[c] = racc[c]; rval[c] = 1; rpos[c] = -1;
                end else rpos[c]++;
            end
            if (rst[c]) rpos[c] = 0;
        end
    endtask

    task automatic compare();
        int e_oe, e_line;
        e_oe = 0; e_line = 0;
        for (int c = NCH - 1; c >= 0; c--)
            if (tpos[c] >= 0) begin
                e_oe = 1;
                e_line = (tbyte[c] >> (7 - tpos[c])) & 1;
            end
        chk("R3 R8 tx_oe", int'(tx_oe), e_oe);
        chk("R3 R10 R4 tx_line", int'(tx_line), e_line);
        for (int c = 0; c < NCH; c++) begin
            chk("R5 tx_ready", int'(tx_ready[c]), int'(!tfresh[c]));
            chk("R6 tx_underrun", int'(tx_underrun[c]), int'(tunder[c]));
            chk("R7 R8 rx_valid", int'(rx_valid[c]), int'(rval[c]));
            if (rval[c]) chk("R7 rx_sample", int'(rx_sample[c*W +: W]), rout[c]);
        end
        chk("R9 tx_clash", int'(tx_clash), int'(m_tclash));
        chk("R9 rx_clash", int'(rx_clash), int'(m_rclash));
    endtask

    initial begin
        int oe_rises;
        bit prev_oe;
        for (int c = 0; c < NCH; c++) begin
            tpos[c] = -1; rpos[c] = -1; tbyte[c] = 0; thold[c] = 0;
            racc[c] = 0; rout[c] = 0; tfresh[c] = 0; tunder[c] = 0;
            tprev[c] = 0; rprev[c] = 0; rval[c] = 0;
        end
        m_tclash = 0; m_rclash = 0; m_rxs = 0;
        oe_rises = 0; prev_oe = 0;
        repeat (4) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 tx_oe", int'(tx_oe), 0);
        chk("R1 tx_line", int'(tx_line), 0);
        chk("R1 tx_ready", int'(tx_ready), 3);
        chk("R1 tx_underrun", int'(tx_underrun), 0);
        chk("R1 rx_valid", int'(rx_valid), 0);
        chk("R1 clash", int'({tx_clash, rx_clash}), 0);
        rst_n = 1'b1;
        for (int n = 0; n < NCYC; n++) begin
            for (int c = 0; c < NCH; c++) begin
                tx_sync[c]  = tsync_f(c, n);
                rx_sync[c]  = rsync_f(c, n);
                tx_valid[c] = tvalid_f(c, n);
                tx_sample[c*W +: W] = W'((n * 53 + c * 17 + 3) & 255);
            end
            rx_line = 1'(((n * n + 3 * n) >> 2) & 1);
            @(negedge clk);
            m_rxs = int'(rx_line);
            @(posedge clk);
            model_step();
            #1;
            compare();
            // R2: long marker at cycle 120 must open a single slot
            if (n >= 119 && n < 150 && tx_oe && !prev_oe) oe_rises++;
            prev_oe = tx_oe;
        end
        chk("R2 single slot for long marker", oe_rises, 1);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(PERIOD * 5000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule